// File: doc/BRIEF.md
# Priority Service Request Scheduler

This block decides which of sixteen timer channels a single shared servicing engine works on next. Each channel gathers pending service causes in a small register. There are four causes: a request from the host, a link raised by another channel, a compare match and an input capture. The host gives every channel a two-bit priority level, and a channel at level zero is switched off.

Whenever the engine reports that it is idle and no grant is outstanding, the scheduler picks one channel. It first takes the highest level that has any pending channel, then the lowest channel number inside that level. It issues a one-cycle grant pulse. The grant carries the channel number and a snapshot of that channel's pending causes. When the engine later reports completion, exactly the causes in the snapshot are cleared, and the scheduler may grant again.

Top module: `svc_sched`

## Requirements
- R1: After reset `gnt_vld_o`, `gnt_ch_o` and `gnt_why_o` are zero, and no channel is pending, so an idle engine receives no grant.
- R2: A pulse on `host_req_i[c]`, `match_ev_i[c]` or `capture_ev_i[c]` marks cause bit 0 (host), bit 2 (match) or bit 3 (capture) of channel c, and the mark appears in `gnt_why_o` when c is granted.
- R3: A cycle with `link_vld_i` high marks cause bit 1 (link) of the channel numbered `link_ch_i`.
- R4: Channel c's priority field is `prio_i[2c+1:2c]`, where 00 is off, 01 is low, 10 is middle and 11 is high. Causes that arrive for a channel whose field is 00 are not recorded, and such a channel is never granted.
- R5: When channels of several levels are pending, the grant goes to a channel of the highest level present.
- R6: Within the winning level, the lowest-numbered pending channel is granted.
- R7: A grant is issued only at a clock edge where `eng_idle_i` is high and no earlier grant is still waiting for completion. `gnt_vld_o` is high for exactly that one cycle, which is the cycle after the edge.
- R8: A grant carries all causes pending for the chosen channel. `gnt_ch_o` and `gnt_why_o` keep their values until the next grant.
- R9: A completion (`eng_done_i` while a grant is outstanding) clears only the causes carried by that grant. A cause that is not in the snapshot, or one that arrives in the same cycle as the completion, stays pending.
- R10: After a completion the next grant can be issued at the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prio_i | input | 32 | Two-bit priority level per channel |
| host_req_i | input | 16 | Host service request pulse per channel |
| match_ev_i | input | 16 | Match event pulse per channel |
| capture_ev_i | input | 16 | Capture event pulse per channel |
| link_vld_i | input | 1 | Link request strobe |
| link_ch_i | input | 4 | Target channel of the link request |
| eng_idle_i | input | 1 | Engine can accept a grant |
| eng_done_i | input | 1 | Engine finished the outstanding grant |
| gnt_vld_o | output | 1 | One-cycle grant pulse |
| gnt_ch_o | output | 4 | Granted channel number |
| gnt_why_o | output | 4 | Causes carried by the grant |

## Verification
The bench builds the block with its default of sixteen channels and a four-bit channel number. With these values both extreme channels, 0 and 15, can be reached, and the link target field is exercised at its full width. Levels are mixed across the whole channel range, so a high level on a high channel number must beat a lower level on a low channel number. Sequences with several completions show the per-cause clear and the same-cycle set rule at the ports.

// File: rtl/svc_sched_pkg.sv
package svc_sched_pkg;

    typedef enum logic [1:0] {
        PRIO_OFF = 2'b00,
        PRIO_LO  = 2'b01,
        PRIO_MID = 2'b10,
        PRIO_HI  = 2'b11
    } prio_e;

    localparam int CAUSE_N    = 4;
    localparam int CAUSE_HOST = 0;
    localparam int CAUSE_LINK = 1;
    localparam int CAUSE_MTCH = 2;
    localparam int CAUSE_CAPT = 3;

    typedef logic [CAUSE_N-1:0] cause_t;

endpackage

// File: rtl/svc_pend_bank.sv
module svc_pend_bank
    import svc_sched_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [2*NUM_CH-1:0]          prio_i,
    input  logic [NUM_CH-1:0]            host_i,
    input  logic [NUM_CH-1:0]            match_i,
    input  logic [NUM_CH-1:0]            capt_i,
    input  logic                         link_vld_i,
    input  logic [CH_W-1:0]              link_ch_i,
    input  logic                         clr_vld_i,
    input  logic [CH_W-1:0]              clr_ch_i,
    input  cause_t                       clr_mask_i,
    output cause_t [NUM_CH-1:0]          pend_o
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cause_t pend_d, pend_q;
        cause_t set_w;
        logic   on_w;

        always_comb begin
            on_w                = (prio_i[2*c +: 2] != PRIO_OFF);
            set_w               = '0;
            set_w[CAUSE_HOST]   = host_i[c];
            set_w[CAUSE_LINK]   = link_vld_i && (link_ch_i == CH_W'(c));
            set_w[CAUSE_MTCH]   = match_i[c];
            set_w[CAUSE_CAPT]   = capt_i[c];
            if (!on_w) set_w    = '0;
            pend_d              = pend_q;
            if (clr_vld_i && (clr_ch_i == CH_W'(c)))
                pend_d          = pend_q & ~clr_mask_i;
            pend_d              = pend_d | set_w;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= '0;
            else        pend_q <= pend_d;
        end

        assign pend_o[c] = pend_q;

        // R4: a switched-off, empty channel stays empty
        a_r4_off_no_record: assert property (@(posedge clk) disable iff (!rst_n)
            (prio_i[2*c +: 2] == 2'b00 && pend_q == '0) |=> (pend_q == '0));

        // R9: a host cause arriving with the clear of its own channel survives
        a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_vld_i && clr_ch_i == CH_W'(c) && host_i[c] && prio_i[2*c +: 2] != 2'b00)
            |=> pend_q[0]);
    end

endmodule

// File: rtl/svc_prio_pick.sv
module svc_prio_pick
    import svc_sched_pkg::*;
#(
    parameter int NUM_CH = 16,
    parameter int CH_W   = 4
) (
    input  logic [2*NUM_CH-1:0]   prio_i,
    input  cause_t [NUM_CH-1:0]   pend_i,
    output logic                  pick_vld_o,
    output logic [CH_W-1:0]       pick_ch_o
);

    localparam int LVL_N = 4;

    logic [LVL_N-1:0][NUM_CH-1:0] elig;
    logic [1:0]                   lvl_d;
    logic [NUM_CH-1:0]            cand_d;

    assign elig[0] = '0;

    for (genvar lv = 1; lv < LVL_N; lv++) begin : g_lvl
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign elig[lv][c] = (|pend_i[c]) && (prio_i[2*c +: 2] == 2'(lv));
        end
    end

    always_comb begin
        lvl_d = 2'd0;
        for (int lv = LVL_N-1; lv >= 1; lv--) begin
            if (lvl_d == 2'd0 && (|elig[lv])) lvl_d = 2'(lv);
        end
        cand_d    = elig[lvl_d];
        pick_ch_o = '0;
        for (int c = NUM_CH-1; c >= 0; c--) begin
            if (cand_d[c]) pick_ch_o = CH_W'(c);
        end
        pick_vld_o = |cand_d;
    end

endmodule

// File: rtl/svc_sched.sv
module svc_sched
    import svc_sched_pkg::*;
#(
    parameter int NUM_CH = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*NUM_CH-1:0]  prio_i,
    input  logic [NUM_CH-1:0]    host_req_i,
    input  logic [NUM_CH-1:0]    match_ev_i,
    input  logic [NUM_CH-1:0]    capture_ev_i,
    input  logic                 link_vld_i,
    input  logic [CH_W-1:0]      link_ch_i,
    input  logic                 eng_idle_i,
    input  logic                 eng_done_i,
    output logic                 gnt_vld_o,
    output logic [CH_W-1:0]      gnt_ch_o,
    output logic [CAUSE_N-1:0]   gnt_why_o
);

    typedef struct packed {
        logic            busy;
        logic            vld;
        logic [CH_W-1:0] ch;
        cause_t          why;
    } sched_t;

    sched_t              st_d, st_q;
    cause_t [NUM_CH-1:0] pend;
    logic                pick_vld;
    logic [CH_W-1:0]     pick_ch;
    logic                clr_vld;

    assign clr_vld = st_q.busy && eng_done_i;

    svc_pend_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .prio_i     (prio_i),
        .host_i     (host_req_i),
        .match_i    (match_ev_i),
        .capt_i     (capture_ev_i),
        .link_vld_i (link_vld_i),
        .link_ch_i  (link_ch_i),
        .clr_vld_i  (clr_vld),
        .clr_ch_i   (st_q.ch),
        .clr_mask_i (st_q.why),
        .pend_o     (pend)
    );

    svc_prio_pick #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_pick (
        .prio_i     (prio_i),
        .pend_i     (pend),
        .pick_vld_o (pick_vld),
        .pick_ch_o  (pick_ch)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (clr_vld) begin
            st_d.busy = 1'b0;
        end else if (!st_q.busy && eng_idle_i && pick_vld) begin
            st_d.busy = 1'b1;
            st_d.vld  = 1'b1;
            st_d.ch   = pick_ch;
            st_d.why  = pend[pick_ch];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign gnt_vld_o = st_q.vld;
    assign gnt_ch_o  = st_q.ch;
    assign gnt_why_o = st_q.why;

    // R7: grant only follows an idle engine
    a_r7_grant_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> $past(eng_idle_i));

    // R7: nothing new while a grant is outstanding
    a_r7_hold_off_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !eng_done_i) |=> !gnt_vld_o);

    // R2: a grant always carries at least one cause
    a_r2_why_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_vld_o |-> (gnt_why_o != '0));

    // R8: grant fields are stable between grants
    a_r8_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_vld_o |-> ($stable(gnt_ch_o) && $stable(gnt_why_o)));

    // R5: the chosen channel is switched on
    a_r5_pick_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> (prio_i[2*pick_ch +: 2] != 2'b00));

    // R6: the chosen channel has something pending
    a_r6_pick_pending: assert property (@(posedge clk) disable iff (!rst_n)
        pick_vld |-> (pend[pick_ch] != '0));

    // R10: a completion frees the scheduler
    a_r10_done_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && eng_done_i) |=> !st_q.busy);

endmodule

// File: tb/svc_sched_bench.sv
module svc_sched_bench;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] prio;
    logic [15:0] host, match, capt;
    logic        lk_vld;
    logic [3:0]  lk_ch;
    logic        idle, done;
    logic        g_vld;
    logic [3:0]  g_ch, g_why;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    svc_sched u_svc_sched (
        .clk          (clk),
        .rst_n        (rst_n),
        .prio_i       (prio),
        .host_req_i   (host),
        .match_ev_i   (match),
        .capture_ev_i (capt),
        .link_vld_i   (lk_vld),
        .link_ch_i    (lk_ch),
        .eng_idle_i   (idle),
        .eng_done_i   (done),
        .gnt_vld_o    (g_vld),
        .gnt_ch_o     (g_ch),
        .gnt_why_o    (g_why)
    );

    typedef struct packed {
        logic [31:0] prio;
        logic [15:0] host;
        logic [15:0] match;
        logic [15:0] capt;
        logic        lv;
        logic [3:0]  lc;
        logic        e_vld;
        logic [3:0]  e_ch;
        logic [3:0]  e_why;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{32'h5555_5555, 16'h0020, 16'h0000, 16'h0000, 1'b0, 4'd0,  1'b1, 4'd5,  4'b0001}, // R2 host
        '{32'h5555_5555, 16'h0200, 16'h0008, 16'h0008, 1'b0, 4'd0,  1'b1, 4'd3,  4'b1100}, // R2 R6
        '{32'h5555_5555, 16'h0000, 16'h0000, 16'h0000, 1'b1, 4'd12, 1'b1, 4'd12, 4'b0010}, // R3 link
        '{32'h5575_5555, 16'h0000, 16'h0404, 16'h0000, 1'b0, 4'd0,  1'b1, 4'd10, 4'b0100}, // R5 high wins
        '{32'hAAAA_AAAA, 16'h4000, 16'h0000, 16'h8000, 1'b0, 4'd0,  1'b1, 4'd14, 4'b0001}, // R6 middle
        '{32'h5555_5554, 16'h0003, 16'h0000, 16'h0000, 1'b0, 4'd0,  1'b1, 4'd1,  4'b0001}, // R4 ch0 off
        '{32'h0000_0000, 16'h0080, 16'h0000, 16'h0000, 1'b0, 4'd0,  1'b0, 4'd0,  4'b0000}, // R4 all off
        '{32'hC001_0002, 16'h0001, 16'h0100, 16'h8000, 1'b0, 4'd0,  1'b1, 4'd15, 4'b1000}, // R5 mixed
        '{32'hFFFF_FFFF, 16'h0001, 16'h0001, 16'h0000, 1'b1, 4'd0,  1'b1, 4'd0,  4'b0111}  // R8 all causes
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; prio = '0; host = '0; match = '0; capt = '0;
        lk_vld = 1'b0; lk_ch = '0; idle = 1'b0; done = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] h, input logic [15:0] m, input logic [15:0] c,
                         input logic lv, input logic [3:0] lc);
        host = h; match = m; capt = c; lk_vld = lv; lk_ch = lc;
        @(negedge clk);
        host = '0; match = '0; capt = '0; lk_vld = 1'b0; lk_ch = '0;
    endtask

    task automatic idle_step();
        idle = 1'b1;
        @(negedge clk);
        idle = 1'b0;
    endtask

    task automatic done_step(input logic [15:0] h);
        done = 1'b1; host = h;
        @(negedge clk);
        done = 1'b0; host = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1 reset state
        do_reset();
        chk("R1 vld", 32'(g_vld), 0);
        chk("R1 ch", 32'(g_ch), 0);
        chk("R1 why", 32'(g_why), 0);
        idle_step();
        chk("R1 nothing pending", 32'(g_vld), 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            do_reset();
            prio = VECS[i].prio;
            pulse(VECS[i].host, VECS[i].match, VECS[i].capt, VECS[i].lv, VECS[i].lc);
            idle_step();
            chk($sformatf("R5/R6 vec%0d vld", i), 32'(g_vld), 32'(VECS[i].e_vld));
            if (VECS[i].e_vld) begin
                chk($sformatf("R6 vec%0d ch", i), 32'(g_ch), 32'(VECS[i].e_ch));
                chk($sformatf("R2 vec%0d why", i), 32'(g_why), 32'(VECS[i].e_why));
            end
        end

        // R4: cause to an off channel is not kept after switching it on
        do_reset();
        prio = 32'h5555_5555; prio[9:8] = 2'b00;
        pulse(16'h0010, '0, '0, 1'b0, 4'd0);
        prio[9:8] = 2'b01;
        idle_step();
        chk("R4 off cause dropped", 32'(g_vld), 0);

        // R7 / R8 / R10
        do_reset();
        prio = 32'h5555_5555;
        pulse(16'h0008, '0, '0, 1'b0, 4'd0);
        repeat (3) @(negedge clk);
        chk("R7 no grant without idle", 32'(g_vld), 0);
        idle_step();
        chk("R7 grant vld", 32'(g_vld), 1);
        chk("R7 grant ch", 32'(g_ch), 3);
        @(negedge clk);
        chk("R7 single-cycle pulse", 32'(g_vld), 0);
        pulse(16'h0002, '0, '0, 1'b0, 4'd0);
        idle_step();
        chk("R7 busy blocks grant", 32'(g_vld), 0);
        chk("R8 ch held", 32'(g_ch), 3);
        chk("R8 why held", 32'(g_why), 1);
        done_step('0);
        idle_step();
        chk("R10 next grant vld", 32'(g_vld), 1);
        chk("R10 next grant ch", 32'(g_ch), 1);

        // R9: unlatched cause and same-cycle cause survive the clear
        do_reset();
        prio = 32'h5555_5555;
        pulse(16'h0004, '0, '0, 1'b0, 4'd0);
        idle_step();
        chk("R9 first why", 32'(g_why), 4'b0001);
        pulse('0, 16'h0004, '0, 1'b0, 4'd0);
        done_step(16'h0004);
        idle_step();
        chk("R9 regrant vld", 32'(g_vld), 1);
        chk("R9 regrant ch", 32'(g_ch), 2);
        chk("R9 regrant why", 32'(g_why), 4'b0101);
        done_step('0);
        idle_step();
        chk("R9 cleared", 32'(g_vld), 0);

        // R6 order over successive grants
        do_reset();
        prio = 32'h5555_5555;
        pulse(16'h0A10, '0, '0, 1'b0, 4'd0);
        idle_step();
        chk("R6 order 1st", 32'(g_ch), 4);
        done_step('0);
        idle_step();
        chk("R6 order 2nd", 32'(g_ch), 9);
        done_step('0);
        idle_step();
        chk("R6 order 3rd", 32'(g_ch), 11);
        done_step('0);
        idle_step();
        chk("R6 drained", 32'(g_vld), 0);

        // R3: link target at the top of the range
        do_reset();
        prio = 32'hFFFF_FFFF;
        pulse('0, '0, '0, 1'b1, 4'd15);
        idle_step();
        chk("R3 link ch15", 32'(g_ch), 15);
        chk("R3 link why", 32'(g_why), 4'b0010);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule